// File: doc/BRIEF.md
# Buffered SPI Master Controller

This block is a serial peripheral interface master for a host that works through simple register-style strobes. The host writes one character into a single transmit holding register. The block moves that character into its shift engine, generates the serial clock, and shifts the character out on MOSI. At the same time it collects a character from MISO. Because the holding register is freed as soon as its character is loaded, the host can queue the next character while the current one is still on the wire. Characters go out back to back, with no gap in the transaction.

Each received character goes into a small receive FIFO, so the shift engine is free for the next character at once. The FIFO depth is two or four entries, chosen at elaboration. The serial clock polarity, the sampling phase, the bit order and a character length of 8 or 9 bits are static configuration inputs. The clock rate comes from an 8-bit divider value. The block can drive the slave-select line by itself, holding it low for a whole multi-character transaction. Request outputs tell a DMA engine or an interrupt controller when the holding register is free and when received data is waiting.

Top module: `spim_core`

## Requirements
- R1: After reset, ss_n is 1, sck equals cfg_cpol, tx_empty_o is 1, rx_avail_o is 0 and ovf_o is 0.
- R2: While characters are shifting, the sck period is 2*(cfg_baud+1) clock cycles (cfg_baud = 0 gives half the reference clock).
- R3: All four modes are supported. sck idles at cfg_cpol. With cfg_cpha = 0, data is sampled on the first (leading) edge of each bit; with cfg_cpha = 1, on the second (trailing) edge. The output bit changes on the other edge. Every character sent on mosi has a character received from miso at the same time.
- R4: With cfg_lsb_first = 1, bit 0 of a character is sent first; with cfg_lsb_first = 0, the most significant bit (bit 7, or bit 8 in 9-bit mode) is sent first. Received bits are placed with the same ordering.
- R5: With cfg_nine_bit = 1, a character is 9 bits (wr_data[8:0], nine sck pulses). With cfg_nine_bit = 0, it is 8 bits: wr_data[8] is not sent, and rd_data[8] reads 0.
- R6: A wr_valid pulse is accepted only while tx_empty_o is 1; an accepted write clears tx_empty_o until the character moves into the shifter. A write while tx_empty_o is 0 is ignored and sends nothing.
- R7: When cfg_hw_ss_en = 1, ss_n goes low when a transaction starts. It stays low across characters that are queued back to back. It rises only after the last character has finished and the holding register is empty. When cfg_hw_ss_en = 0, ss_n stays 1.
- R8: When cfg_rx_en = 1, each received character enters a FIFO of RX_DEPTH entries. rx_avail_o is 1 while the FIFO holds data. rd_data shows the oldest entry, and an rd_en pulse removes it, so characters are read in order of arrival.
- R9: A character that completes while the FIFO is full is discarded, and it sets ovf_o. ovf_o stays 1 until an ovf_clr pulse.
- R10: When cfg_rx_en = 0, received characters are not stored and rx_avail_o stays 0.
- R11: dma_tx_req_o equals tx_empty_o. dma_rx_req_o equals rx_avail_o. irq_o is 1 whenever tx_empty_o, rx_avail_o or ovf_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: bit 0 sent first |
| cfg_nine_bit | input | 1 | 1: 9-bit characters, 0: 8-bit |
| cfg_rx_en | input | 1 | Store received characters |
| cfg_hw_ss_en | input | 1 | Drive ss_n from the transfer state |
| cfg_baud | input | BAUD_W | Clock divider value |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| tx_empty_o | output | 1 | Holding register is free |
| rd_en | input | 1 | Remove the oldest received character |
| rd_data | output | 9 | Oldest received character |
| rx_avail_o | output | 1 | Receive FIFO not empty |
| ovf_o | output | 1 | Sticky receive overflow |
| ovf_clr | input | 1 | Clear the overflow flag |
| irq_o | output | 1 | Interrupt request |
| dma_tx_req_o | output | 1 | DMA request to refill the holding register |
| dma_rx_req_o | output | 1 | DMA request to read a received character |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The exchange is run in each of the four polarity and phase modes, using a pair of characters sent back to back. An edge-aware slave model returns its own reply pattern. A mistake in the sampling edge or in the output-change edge therefore corrupts at least one of the two directions, and an early release of select between the characters shows up as an extra rising edge on ss_n. Single-bit-set patterns are sent in both bit orders and split the two orders on the very first bit. The 9-bit pattern has bit 8 set, and a write with bit 8 set in 8-bit mode exposes any leak of the ninth bit. Five characters sent into the four-deep FIFO with no reads separate the stored order, the discard of the newest character and the sticky flag. Queued, ignored and receive-disabled writes are each checked at the serial pins and at the FIFO status.

// File: rtl/spim_pkg.sv
package spim_pkg;

   localparam int CHAR_W = 9;
   localparam int BIT_IW = $clog2(CHAR_W);

   typedef logic [CHAR_W-1:0] char_t;
   typedef logic [BIT_IW-1:0] bitidx_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2
   } phase_e;

   // index of the k-th bit on the wire inside a character
   function automatic bitidx_t wire_pos(input bitidx_t k, input logic lsb, input logic nine);
      bitidx_t top;
      top = nine ? bitidx_t'(CHAR_W - 1) : bitidx_t'(CHAR_W - 2);
      wire_pos = lsb ? k : bitidx_t'(top - k);
   endfunction

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
   parameter int BAUD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [BAUD_W-1:0] baud,
   output logic              tick
);

   logic [BAUD_W-1:0] cnt_q;

   assign tick = run && (cnt_q == baud);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick || restart) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/spim_rxfifo.sv
module spim_rxfifo
   import spim_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  push,
   input  char_t push_data,
   input  logic  pop,
   output char_t head,
   output logic  avail,
   output logic  drop
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   char_t          mem_q [DEPTH];
   logic [AW-1:0]  wptr_q;
   logic [AW-1:0]  rptr_q;
   logic [CW-1:0]  cnt_q;
   logic           full;
   logic           do_pop;
   logic           do_push;

   assign full    = (cnt_q == CW'(DEPTH));
   assign avail   = (cnt_q != '0);
   assign do_pop  = pop && avail;
   assign do_push = push && (!full || do_pop);
   assign drop    = push && full && !do_pop;
   assign head    = mem_q[rptr_q];

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wptr_q <= '0;
               rptr_q <= '0;
            end else begin
               if (do_push) wptr_q <= wptr_q + 1'b1;
               if (do_pop)  rptr_q <= rptr_q + 1'b1;
            end
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wptr_q <= '0;
               rptr_q <= '0;
            end else begin
               if (do_push) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
               if (do_pop)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (do_push && !do_pop) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (do_pop && !do_push) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
      end else if (do_push) begin
         mem_q[wptr_q] <= push_data;
      end
   end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
   import spim_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cpol,
   input  logic  cpha,
   input  logic  lsb_first,
   input  logic  nine_bit,
   input  logic  tick,
   input  logic  hold_full,
   input  char_t hold_data,
   input  logic  miso,
   output logic  load,
   output logic  run,
   output logic  char_done,
   output char_t rx_char,
   output logic  sck,
   output logic  mosi,
   output logic  active
);

   phase_e  st_q;
   bitidx_t k_q;
   logic    half_q;
   char_t   txd_q;
   char_t   rxd_q;
   char_t   rx_q;
   char_t   rx_next;
   logic    mosi_q;
   logic    done_q;
   bitidx_t last_k;
   bitidx_t pos_k;
   bitidx_t pos_k1;
   logic    lead_edge;
   logic    trail_edge;
   logic    char_end;

   assign last_k     = nine_bit ? bitidx_t'(CHAR_W - 1) : bitidx_t'(CHAR_W - 2);
   assign pos_k      = wire_pos(k_q, lsb_first, nine_bit);
   assign pos_k1     = wire_pos(bitidx_t'(k_q + 1'b1), lsb_first, nine_bit);
   assign lead_edge  = (st_q == ST_SHIFT) && tick && !half_q;
   assign trail_edge = (st_q == ST_SHIFT) && tick && half_q;
   assign char_end   = trail_edge && (k_q == last_k);
   assign load       = hold_full && ((st_q == ST_IDLE) || (st_q == ST_TAIL) || char_end);
   assign run        = (st_q != ST_IDLE);
   assign active     = (st_q != ST_IDLE);
   assign sck        = cpol ^ half_q;
   assign mosi       = mosi_q;
   assign char_done  = done_q;
   assign rx_char    = rx_q;

   // received character including a bit sampled on the final trailing edge
   always_comb begin
      rx_next = rxd_q;
      if (cpha) rx_next[pos_k] = miso;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         k_q    <= '0;
         half_q <= 1'b0;
         txd_q  <= '0;
         rxd_q  <= '0;
         mosi_q <= 1'b0;
      end else if (load) begin
         st_q   <= ST_SHIFT;
         k_q    <= '0;
         half_q <= 1'b0;
         txd_q  <= hold_data;
         rxd_q  <= '0;
         if (!cpha) mosi_q <= hold_data[wire_pos('0, lsb_first, nine_bit)];
      end else begin
         case (st_q)
            ST_SHIFT: begin
               if (lead_edge) begin
                  half_q <= 1'b1;
                  if (cpha) mosi_q <= txd_q[pos_k];
                  else      rxd_q[pos_k] <= miso;
               end else if (trail_edge) begin
                  half_q <= 1'b0;
                  if (cpha) rxd_q[pos_k] <= miso;
                  if (k_q == last_k) begin
                     st_q <= ST_TAIL;
                  end else begin
                     k_q <= k_q + 1'b1;
                     if (!cpha) mosi_q <= txd_q[pos_k1];
                  end
               end
            end
            ST_TAIL: begin
               if (tick) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         rx_q   <= '0;
      end else begin
         done_q <= char_end;
         if (char_end) rx_q <= rx_next;
      end
   end

endmodule

// File: rtl/spim_core.sv
module spim_core
   import spim_pkg::*;
#(
   parameter int BAUD_W   = 8,
   parameter int RX_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_lsb_first,
   input  logic              cfg_nine_bit,
   input  logic              cfg_rx_en,
   input  logic              cfg_hw_ss_en,
   input  logic [BAUD_W-1:0] cfg_baud,
   input  logic              wr_valid,
   input  logic [8:0]        wr_data,
   output logic              tx_empty_o,
   input  logic              rd_en,
   output logic [8:0]        rd_data,
   output logic              rx_avail_o,
   output logic              ovf_o,
   input  logic              ovf_clr,
   output logic              irq_o,
   output logic              dma_tx_req_o,
   output logic              dma_rx_req_o,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic              ss_n
);

   generate
      if (!(RX_DEPTH == 2 || RX_DEPTH == 4)) begin : g_bad_depth
         $error("spim_core: RX_DEPTH must be 2 or 4");
      end
      if (BAUD_W < 1 || BAUD_W > 16) begin : g_bad_baud
         $error("spim_core: BAUD_W out of range");
      end
   endgenerate

   char_t hold_q;
   logic  hold_full_q;
   logic  accept;
   logic  load;
   logic  run;
   logic  tick;
   logic  char_done;
   char_t rx_char;
   logic  active;
   logic  fifo_drop;
   logic  ovf_q;
   char_t push_data;

   assign accept = wr_valid && !hold_full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full_q <= 1'b0;
         hold_q      <= '0;
      end else if (accept) begin
         hold_full_q <= 1'b1;
         hold_q      <= wr_data;
      end else if (load) begin
         hold_full_q <= 1'b0;
      end
   end

   spim_baud #(.BAUD_W(BAUD_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (load),
      .baud    (cfg_baud),
      .tick    (tick)
   );

   spim_shifter u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpol      (cfg_cpol),
      .cpha      (cfg_cpha),
      .lsb_first (cfg_lsb_first),
      .nine_bit  (cfg_nine_bit),
      .tick      (tick),
      .hold_full (hold_full_q),
      .hold_data (hold_q),
      .miso      (miso),
      .load      (load),
      .run       (run),
      .char_done (char_done),
      .rx_char   (rx_char),
      .sck       (sck),
      .mosi      (mosi),
      .active    (active)
   );

   assign push_data = cfg_nine_bit ? rx_char : {1'b0, rx_char[CHAR_W-2:0]};

   spim_rxfifo #(.DEPTH(RX_DEPTH)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (char_done && cfg_rx_en),
      .push_data (push_data),
      .pop       (rd_en),
      .head      (rd_data),
      .avail     (rx_avail_o),
      .drop      (fifo_drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= 1'b0;
      else        ovf_q <= (ovf_q && !ovf_clr) || fifo_drop;
   end

   assign ovf_o        = ovf_q;
   assign tx_empty_o   = !hold_full_q;
   assign ss_n         = !(cfg_hw_ss_en && active);
   assign dma_tx_req_o = !hold_full_q;
   assign dma_rx_req_o = rx_avail_o;
   assign irq_o        = !hold_full_q || rx_avail_o || ovf_q;

endmodule

// File: rtl/spim_core_chk.sv
module spim_core_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_cpol,
   input logic cfg_rx_en,
   input logic cfg_hw_ss_en,
   input logic wr_valid,
   input logic tx_empty_o,
   input logic rd_en,
   input logic rx_avail_o,
   input logic ovf_o,
   input logic ovf_clr,
   input logic sck,
   input logic ss_n
);

   // R7
   ss_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_n) |-> tx_empty_o);

   // R6
   tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_empty_o) |-> $past(wr_valid));

   // R3
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hw_ss_en && ss_n) |-> (sck == cfg_cpol));

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !ovf_clr) |=> ovf_o);

   // R9
   ovf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_o) |-> $past(rx_avail_o));

   // R8
   rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_avail_o) |-> $past(rd_en));

   // R10
   rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rx_en && !rx_avail_o) |=> !rx_avail_o);

endmodule

bind spim_core spim_core_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_cpol     (cfg_cpol),
   .cfg_rx_en    (cfg_rx_en),
   .cfg_hw_ss_en (cfg_hw_ss_en),
   .wr_valid     (wr_valid),
   .tx_empty_o   (tx_empty_o),
   .rd_en        (rd_en),
   .rx_avail_o   (rx_avail_o),
   .ovf_o        (ovf_o),
   .ovf_clr      (ovf_clr),
   .sck          (sck),
   .ss_n         (ss_n)
);

// File: tb/spim_core_tb_top.sv
`timescale 1ns/1ps
module spim_core_tb_top;

   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpol = 1'b0, cpha = 1'b0, lsb = 1'b0, nine = 1'b0;
   logic       rx_en = 1'b1, hw_ss = 1'b1;
   logic [7:0] baud = 8'd1;
   logic       wr_valid = 1'b0;
   logic [8:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic       ovf_clr = 1'b0;
   logic       miso = 1'b0;
   logic       tx_empty, rx_avail, ovf, irq, dtx, drx, sck, mosi, ss_n;
   logic [8:0] rd_data;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   spim_core #(.BAUD_W(8), .RX_DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha),
      .cfg_lsb_first(lsb), .cfg_nine_bit(nine), .cfg_rx_en(rx_en),
      .cfg_hw_ss_en(hw_ss), .cfg_baud(baud), .wr_valid(wr_valid),
      .wr_data(wr_data), .tx_empty_o(tx_empty), .rd_en(rd_en),
      .rd_data(rd_data), .rx_avail_o(rx_avail), .ovf_o(ovf),
      .ovf_clr(ovf_clr), .irq_o(irq), .dma_tx_req_o(dtx),
      .dma_rx_req_o(drx), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   // ---------------- slave model ----------------
   logic       slv_armed = 1'b0;
   int         slv_n = 0;
   logic [8:0] slv_reply [8];
   logic [8:0] slv_got [8];
   logic       slv_raw [64];
   int         rise_cnt = 0;
   time        t_rise [2];
   int         ss_rise = 0;
   int         ss_fall = 0;
   logic [8:0] tx_vals [8];

   function automatic int nb();
      return nine ? 9 : 8;
   endfunction

   function automatic int bpos(int j);
      return lsb ? j : nb() - 1 - j;
   endfunction

   task automatic drive_miso();
      int c;
      c = slv_n / nb();
      miso = (c < 8) ? slv_reply[c][bpos(slv_n % nb())] : 1'b0;
   endtask

   always @(sck) begin
      int c;
      if (slv_armed) begin
         #1;
         if ((sck === 1'b1) == (cpol == cpha)) begin
            c = slv_n / nb();
            if (c < 8) slv_got[c][bpos(slv_n % nb())] = mosi;
            if (slv_n < 64) slv_raw[slv_n] = mosi;
            slv_n++;
         end else begin
            drive_miso();
         end
         if (sck === 1'b1) begin
            if (rise_cnt < 2) t_rise[rise_cnt] = $time;
            rise_cnt++;
         end
      end
   end

   always @(posedge ss_n) if (slv_armed) ss_rise++;
   always @(negedge ss_n) if (slv_armed) ss_fall++;

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic arm();
      @(negedge clk);
      slv_n = 0;
      rise_cnt = 0;
      ss_rise = 0;
      ss_fall = 0;
      for (int i = 0; i < 8; i++) slv_got[i] = '0;
      for (int i = 0; i < 64; i++) slv_raw[i] = 1'b0;
      drive_miso();
      slv_armed = 1'b1;
   endtask

   task automatic host_write(input logic [8:0] v);
      wr_valid = 1'b1;
      wr_data  = v;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic wait_empty();
      int t = 0;
      while (!tx_empty && t < 20000) begin @(negedge clk); t++; end
   endtask

   task automatic wait_bits(input int target, input string req);
      int t = 0;
      while (slv_n < target && t < 20000) begin @(negedge clk); t++; end
      check(slv_n >= target, req, "bit count reached", slv_n, target);
      repeat (4 * (int'(baud) + 1) + 8) @(negedge clk);
   endtask

   task automatic xfer(input int n, input string req);
      arm();
      for (int i = 0; i < n; i++) begin
         wait_empty();
         host_write(tx_vals[i]);
      end
      wait_bits(n * nb(), req);
      slv_armed = 1'b0;
   endtask

   task automatic rd_check(input logic [8:0] exp, input string req);
      @(negedge clk);
      check(rx_avail === 1'b1, req, "rx_avail before read", rx_avail, 1);
      check(rd_data === exp, req, "rd_data", rd_data, exp);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic set_cfg(input logic p, input logic h, input logic l, input logic n9,
                          input logic [7:0] b);
      @(negedge clk);
      cpol = p; cpha = h; lsb = l; nine = n9; baud = b;
      repeat (2) @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      check(ss_n === 1'b1, "R1", "ss_n after reset", ss_n, 1);
      check(sck === cpol, "R1", "sck after reset", sck, cpol);
      check(tx_empty === 1'b1, "R1", "tx_empty after reset", tx_empty, 1);
      check(rx_avail === 1'b0, "R1", "rx_avail after reset", rx_avail, 0);
      check(ovf === 1'b0, "R1", "ovf after reset", ovf, 0);
      check(dtx === 1'b1 && drx === 1'b0 && irq === 1'b1, "R11", "requests after reset",
            {irq, dtx, drx}, 3'b110);
   endtask

   task automatic t_modes();
      for (int m = 0; m < 4; m++) begin
         set_cfg(m[1], m[0], 1'b0, 1'b0, 8'd1);
         tx_vals[0] = 9'h0A5; tx_vals[1] = 9'h03C;
         slv_reply[0] = 9'h05A; slv_reply[1] = 9'h0C3;
         xfer(2, "R3");
         check(slv_got[0] == 9'h0A5, "R3", "mosi char 0", slv_got[0], 9'h0A5);
         check(slv_got[1] == 9'h03C, "R3", "mosi char 1", slv_got[1], 9'h03C);
         check(ss_rise == 1 && ss_fall == 1, "R7", "one select window for two chars",
               ss_rise * 16 + ss_fall, 17);
         check(sck === cpol && ss_n === 1'b1, "R3", "idle sck level", sck, cpol);
         rd_check(9'h05A, "R3");
         rd_check(9'h0C3, "R8");
         check(rx_avail === 1'b0, "R8", "fifo drained", rx_avail, 0);
      end
   endtask

   task automatic t_order();
      set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
      tx_vals[0] = 9'h001; slv_reply[0] = 9'h000;
      xfer(1, "R4");
      check(slv_raw[0] == 1'b0 && slv_raw[7] == 1'b1, "R4", "msb-first wire order",
            {slv_raw[0], slv_raw[7]}, 2'b01);
      rd_check(9'h000, "R4");
      set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 8'd1);
      tx_vals[0] = 9'h001; slv_reply[0] = 9'h080;
      xfer(1, "R4");
      check(slv_raw[0] == 1'b1 && slv_raw[7] == 1'b0, "R4", "lsb-first wire order",
            {slv_raw[0], slv_raw[7]}, 2'b10);
      rd_check(9'h080, "R4");
   endtask

   task automatic t_nine();
      set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 8'd1);
      tx_vals[0] = 9'h1A5; slv_reply[0] = 9'h10F;
      xfer(1, "R5");
      check(slv_got[0] == 9'h1A5, "R5", "9-bit char sent", slv_got[0], 9'h1A5);
      check(rise_cnt == 9, "R5", "nine sck pulses", rise_cnt, 9);
      rd_check(9'h10F, "R5");
      set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
      tx_vals[0] = 9'h1FF; slv_reply[0] = 9'h0FF;
      xfer(1, "R5");
      check(rise_cnt == 8, "R5", "eight sck pulses", rise_cnt, 8);
      rd_check(9'h0FF, "R5");
   endtask

   task automatic t_baud();
      for (int b = 0; b < 2; b++) begin
         set_cfg(1'b0, 1'b0, 1'b0, 1'b0, (b == 0) ? 8'd0 : 8'd3);
         tx_vals[0] = 9'h055; slv_reply[0] = 9'h0AA;
         xfer(1, "R2");
         check((t_rise[1] - t_rise[0]) == ((b == 0) ? 16 : 64), "R2", "sck period ns",
               int'(t_rise[1] - t_rise[0]), (b == 0) ? 16 : 64);
         rd_check(9'h0AA, "R2");
      end
   endtask

   task automatic t_holding();
      set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 8'd2);
      rx_en = 1'b0;
      slv_reply[0] = 9'h011; slv_reply[1] = 9'h022; slv_reply[2] = 9'h033;
      arm();
      host_write(9'h0C1);
      wait_empty();
      host_write(9'h0C2);
      check(tx_empty === 1'b0, "R6", "holding full after queued write", tx_empty, 0);
      check(dtx === 1'b0, "R11", "tx request drops", dtx, 0);
      host_write(9'h0C3);
      wait_bits(16, "R6");
      check(slv_n == 16, "R6", "write while full ignored", slv_n, 16);
      check(slv_got[0] == 9'h0C1 && slv_got[1] == 9'h0C2, "R6", "queued char order",
            slv_got[1], 9'h0C2);
      check(ss_rise == 1, "R7", "select held over queued char", ss_rise, 1);
      check(rx_avail === 1'b0, "R10", "nothing stored with receiver off", rx_avail, 0);
      slv_armed = 1'b0;
      rx_en = 1'b1;
   endtask

   task automatic t_overflow();
      set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 8'd0);
      for (int i = 0; i < 5; i++) begin
         tx_vals[i] = 9'(8'h80 + i);
         slv_reply[i] = 9'(8'h11 * (i + 1));
      end
      xfer(DEPTH + 1, "R9");
      check(ovf === 1'b1, "R9", "overflow set", ovf, 1);
      check(drx === 1'b1 && irq === 1'b1, "R11", "rx request with data", {irq, drx}, 2'b11);
      for (int i = 0; i < DEPTH; i++) rd_check(9'(8'h11 * (i + 1)), "R8");
      @(negedge clk);
      check(rx_avail === 1'b0, "R9", "fifth char discarded", rx_avail, 0);
      check(ovf === 1'b1, "R9", "overflow sticky", ovf, 1);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      @(negedge clk);
      check(ovf === 1'b0, "R9", "overflow cleared", ovf, 0);
   endtask

   task automatic t_rx_off();
      set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 8'd1);
      rx_en = 1'b0;
      tx_vals[0] = 9'h066; slv_reply[0] = 9'h099;
      xfer(1, "R10");
      check(rx_avail === 1'b0 && drx === 1'b0, "R10", "receiver off stores nothing",
            rx_avail, 0);
      rx_en = 1'b1;
   endtask

   task automatic t_no_ss();
      set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 8'd1);
      hw_ss = 1'b0;
      tx_vals[0] = 9'h03A; slv_reply[0] = 9'h0E1;
      xfer(1, "R7");
      check(ss_fall == 0 && ss_n === 1'b1, "R7", "select idle when disabled", ss_fall, 0);
      check(slv_got[0] == 9'h03A, "R7", "data still sent", slv_got[0], 9'h03A);
      rd_check(9'h0E1, "R7");
      hw_ss = 1'b1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_modes();
      t_order();
      t_nine();
      t_baud();
      t_holding();
      t_overflow();
      t_rx_off();
      t_no_ss();
      finish_run();
   end

endmodule